// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is an SPI master that a host processor drives one word at a time through a small register window. The host sets the shifting options once in a configuration register: word size, clock phase and polarity, chip-select level, target slave and transfer direction. It sets the SCLK rate in a divider register. It then pushes words through a transmit-data register and collects received words from a receive-data register. A global run bit asserts the chosen chip select and holds it for as many words as the host sends, so one multi-word message never releases the slave.

Each accepted transmit-data write starts exactly one word. The direction field decides what happens on the wire. A full-duplex word drives and captures. A receive-only word holds MOSI low, and the write is only a trigger. A transmit-only word leaves the receive side untouched. Back-pressure is carried by status bits rather than by a handshake. While TX-ready reads 0, a transmit-data write is dropped. End-of-transfer reads 1 whenever the shifter is idle. RX-ready is set when a word with receive data finishes and is cleared when the receive-data register is read.

Registers sit on a 64-bit stride, and the byte address bits [5:3] select the register. Reads are combinational on the address, and a write is taken on the clock edge where the write strobe is high.

Top module: `spi_pio_master`

## Requirements
- R1: After reset every chip select is at its inactive level (high, since the select-level bit resets to 0). SCLK and MOSI are low. Configuration, divider and receive data read 0, and status reads 0x54.
- R2: Byte offset 0x00 is configuration and 0x08 is status. 0x10 is a FIFO-control slot that reads 0 and ignores writes. 0x18 is transmit data, 0x20 is receive data and 0x28 is the divider in bits 13:0. Any other offset reads 0. Configuration bits 11:9 and 63:27 read 0, and every other configuration bit reads back as written.
- R3: With the run bit (configuration bit 26) set, cs_o[n] is driven to its active level, where n is configuration bits 17:14. Select-level bit 2 gives that level (1 = active high). The select stays active across words until the run bit is cleared. A slave number of NUM_CS or above drives no select, and at most one select is ever active.
- R4: Status bit 0 is RX-ready and bit 1 is TX-ready (run bit set and shifter idle). Bit 2 is end-of-transfer (shifter idle). Bits 4 and 6 read 1, and bits 3, 5, 7 and 63:8 read 0.
- R5: Configuration bits 8:4 hold the word length minus one. A value below 3 gives a 4-bit word. A word produces exactly 2×length SCLK edges, most significant bit first.
- R6: Transfer mode in configuration bits 13:12: 0 is full duplex, 1 is receive only (MOSI held 0, written data discarded), 2 is transmit only (receive data and RX-ready unchanged), and 3 behaves as full duplex.
- R7: SCLK idles at polarity bit 1. With phase bit 0 clear, MISO is captured on leading edges and MOSI changes on trailing edges. With it set, MOSI changes on leading edges after the first and MISO is captured on trailing edges.
- R8: With divider value D, each SCLK half period lasts D+1 clock cycles. End-of-transfer reads 0 for exactly 2×length×(D+1) cycles, starting the cycle after the accepted write. D = 16383 gives a first edge 16384 cycles after the write, which is a 2^15 ratio.
- R9: A transmit-data write while TX-ready is 0, whether the shifter is busy or the run bit is clear, has no effect on the wire or on the word in flight.
- R10: Configuration and divider writes are ignored while a word is in flight.
- R11: When a mode 0, 1 or 3 word ends, RX-ready rises in the same cycle that end-of-transfer returns to 1. The word is readable right-justified and zero-extended. Reading offset 0x20 clears RX-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Register write strobe |
| host_rd_en | input | 1 | Register read strobe (side effect on receive data only) |
| host_addr | input | 6 | Byte address, bits 5:3 select the register |
| host_wdata | input | 64 | Write data |
| host_rdata | output | 64 | Read data, combinational on host_addr |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to slaves |
| miso_i | input | 1 | Serial data from slaves |
| cs_o | output | NUM_CS | Chip selects, level set by configuration |

## Verification
A wrong edge counter or divider count shows up within the word itself. The SCLK edge count seen by a slave model and the number of cycles that end-of-transfer stays low both diverge on the first affected word. A wrong shift or capture order corrupts the word captured at MOSI, or the word read back, on that same word. A configuration change that slips through during a word shows up as a changed readback or a moved chip select right after the word. A stale or lost RX-ready shows on the very next status read.

// File: rtl/spi_pio_pkg.sv
package spi_pio_pkg;

  localparam int HOST_AW = 6;
  localparam int IDX_W   = 3;

  localparam logic [IDX_W-1:0] IDX_CFG  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_STAT = 3'd1;
  localparam logic [IDX_W-1:0] IDX_FCTL = 3'd2;
  localparam logic [IDX_W-1:0] IDX_TXD  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_RXD  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_DIV  = 3'd5;

  typedef enum logic [1:0] {
    XFER_DUPLEX = 2'd0,
    XFER_RX     = 2'd1,
    XFER_TX     = 2'd2,
    XFER_ALT    = 2'd3
  } xfer_mode_e;

  typedef struct packed {
    logic       run_en;
    logic       fifo_en;
    logic [6:0] word_cnt;
    logic [3:0] slave_sel;
    xfer_mode_e mode;
    logic [4:0] len_m1;
    logic       tx_enable;
    logic       sel_pol;
    logic       cpol;
    logic       cpha;
  } cfg_t;

  function automatic cfg_t cfg_unpack(logic [26:0] w);
    cfg_t c;
    c.cpha      = w[0];
    c.cpol      = w[1];
    c.sel_pol   = w[2];
    c.tx_enable = w[3];
    c.len_m1    = w[8:4];
    c.mode      = xfer_mode_e'(w[13:12]);
    c.slave_sel = w[17:14];
    c.word_cnt  = w[24:18];
    c.fifo_en   = w[25];
    c.run_en    = w[26];
    return c;
  endfunction

  function automatic logic [63:0] cfg_pack(cfg_t c);
    return 64'({c.run_en, c.fifo_en, c.word_cnt, c.slave_sel, c.mode,
                3'b000, c.len_m1, c.tx_enable, c.sel_pol, c.cpol, c.cpha});
  endfunction

endpackage

// File: rtl/spi_pio_clkdiv.sv
module spi_pio_clkdiv #(
  parameter int DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // The half-period counter never runs past the programmed limit.
  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> cnt_q <= div_i) else $error("divider past limit"); // R8

endmodule

// File: rtl/spi_pio_shifter.sv
module spi_pio_shifter
  import spi_pio_pkg::*;
#(
  parameter int MAX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [MAX_W-1:0] word_i,
  input  logic [$clog2(MAX_W)-1:0] len_m1_i,
  input  xfer_mode_e       mode_i,
  input  logic             cpha_i,
  input  logic             cpol_i,
  input  logic             tick_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             done_o,
  output logic             rx_keep_o,
  output logic [MAX_W-1:0] rx_word_o
);

  localparam int LEN_W  = $clog2(MAX_W) + 1;
  localparam int EDGE_W = LEN_W + 1;

  logic             busy_q, lvl_q, cpha_q;
  xfer_mode_e       mode_q;
  logic [LEN_W-1:0] len_q, len_d;
  logic [EDGE_W-1:0] edge_q, last_edge;
  logic [MAX_W-1:0] tx_sh_q, rx_sh_q, tx_load;
  logic             lead, sample_now, shift_now, last_now;

  assign len_d = (len_m1_i < (LEN_W-1)'(3)) ? LEN_W'(4)
               : LEN_W'(len_m1_i) + LEN_W'(1);
  assign tx_load = (mode_i == XFER_RX) ? '0
                 : word_i << (LEN_W'(MAX_W) - len_d);

  assign lead       = ~edge_q[0];
  assign sample_now = cpha_q ? ~lead : lead;
  assign shift_now  = ~sample_now && !(cpha_q && edge_q == '0);
  assign last_edge  = {len_q, 1'b0} - EDGE_W'(1);
  assign last_now   = (edge_q == last_edge);

  assign busy_o    = busy_q;
  assign done_o    = busy_q && tick_i && last_now;
  assign rx_keep_o = (mode_q != XFER_TX);
  assign rx_word_o = sample_now ? {rx_sh_q[MAX_W-2:0], miso_i} : rx_sh_q;
  assign sclk_o    = cpol_i ^ lvl_q;
  assign mosi_o    = busy_q & tx_sh_q[MAX_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      lvl_q   <= 1'b0;
      cpha_q  <= 1'b0;
      mode_q  <= XFER_DUPLEX;
      len_q   <= LEN_W'(4);
      edge_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      lvl_q   <= 1'b0;
      cpha_q  <= cpha_i;
      mode_q  <= mode_i;
      len_q   <= len_d;
      edge_q  <= '0;
      tx_sh_q <= tx_load;
      rx_sh_q <= '0;
    end else if (busy_q && tick_i) begin
      edge_q <= edge_q + 1'b1;
      if (sample_now) rx_sh_q <= {rx_sh_q[MAX_W-2:0], miso_i};
      if (shift_now)  tx_sh_q <= {tx_sh_q[MAX_W-2:0], 1'b0};
      if (last_now) begin
        busy_q <= 1'b0;
        lvl_q  <= 1'b0;
      end else begin
        lvl_q  <= ~lvl_q;
      end
    end
  end

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sclk_o == cpol_i) else $error("sclk not idle"); // R7
  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> edge_q < {len_q, 1'b0}) else $error("edge overrun"); // R5
  AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> len_q >= LEN_W'(4)) else $error("word too short"); // R5

endmodule

// File: rtl/spi_pio_regs.sv
module spi_pio_regs
  import spi_pio_pkg::*;
#(
  parameter int DIV_W = 14,
  parameter int MAX_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [63:0]        wdata_i,
  output logic [63:0]        rdata_o,
  input  logic               busy_i,
  input  logic               done_i,
  input  logic               rx_keep_i,
  input  logic [MAX_W-1:0]   rx_word_i,
  output cfg_t               cfg_o,
  output logic [DIV_W-1:0]   div_o,
  output logic               start_o,
  output logic [MAX_W-1:0]   tx_word_o
);

  cfg_t             cfg_q;
  logic [DIV_W-1:0] div_q;
  logic [MAX_W-1:0] rx_data_q;
  logic             rx_rdy_q;
  logic [IDX_W-1:0] idx;
  logic             tx_rdy, wr_cfg, wr_div, rd_rx;
  logic [63:0]      status_w;
  logic             unused_bits;

  assign idx     = addr_i[HOST_AW-1:3];
  assign tx_rdy  = cfg_q.run_en && !busy_i;
  assign wr_cfg  = wr_en_i && (idx == IDX_CFG) && !busy_i;
  assign wr_div  = wr_en_i && (idx == IDX_DIV) && !busy_i;
  assign start_o = wr_en_i && (idx == IDX_TXD) && tx_rdy;
  assign rd_rx   = rd_en_i && (idx == IDX_RXD);

  assign cfg_o     = cfg_q;
  assign div_o     = div_q;
  assign tx_word_o = wdata_i[MAX_W-1:0];
  assign status_w  = 64'({1'b0, 1'b1, 1'b0, 1'b1, 1'b0, ~busy_i, tx_rdy, rx_rdy_q});
  assign unused_bits = ^{wdata_i[63:27], addr_i[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      div_q     <= '0;
      rx_data_q <= '0;
      rx_rdy_q  <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= cfg_unpack(wdata_i[26:0]);
      if (wr_div) div_q <= wdata_i[DIV_W-1:0];
      if (done_i && rx_keep_i) begin
        rx_rdy_q  <= 1'b1;
        rx_data_q <= rx_word_i;
      end else if (rd_rx) begin
        rx_rdy_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (idx)
      IDX_CFG:  rdata_o = cfg_pack(cfg_q);
      IDX_STAT: rdata_o = status_w;
      IDX_RXD:  rdata_o = 64'(rx_data_q);
      IDX_DIV:  rdata_o = 64'(div_q);
      default:  rdata_o = '0;
    endcase
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(cfg_q) && $stable(div_q)) else $error("config moved in flight"); // R10
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !done_i) |=> !rx_rdy_q) else $error("rx ready not cleared"); // R11
  AST_BUSY_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> cfg_q.run_en) else $error("shifting without run bit"); // R3

endmodule

// File: rtl/spi_pio_master.sv
module spi_pio_master
  import spi_pio_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int MAX_W  = 32,
  parameter int DIV_W  = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [63:0]        host_wdata,
  output logic [63:0]        host_rdata,
  output logic               sclk_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic [NUM_CS-1:0]  cs_o
);

  cfg_t             cfg;
  logic [DIV_W-1:0] div;
  logic             start, busy, done, rx_keep, tick;
  logic [MAX_W-1:0] tx_word, rx_word;
  logic [NUM_CS-1:0] cs_act;

  spi_pio_regs #(.DIV_W(DIV_W), .MAX_W(MAX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(host_wr_en), .rd_en_i(host_rd_en),
    .addr_i(host_addr), .wdata_i(host_wdata), .rdata_o(host_rdata),
    .busy_i(busy), .done_i(done), .rx_keep_i(rx_keep), .rx_word_i(rx_word),
    .cfg_o(cfg), .div_o(div), .start_o(start), .tx_word_o(tx_word)
  );

  spi_pio_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
    .clk(clk), .rst_n(rst_n), .run_i(busy), .div_i(div), .tick_o(tick)
  );

  spi_pio_shifter #(.MAX_W(MAX_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start_i(start), .word_i(tx_word),
    .len_m1_i(cfg.len_m1), .mode_i(cfg.mode), .cpha_i(cfg.cpha),
    .cpol_i(cfg.cpol), .tick_i(tick), .miso_i(miso_i), .busy_o(busy),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .done_o(done), .rx_keep_o(rx_keep),
    .rx_word_o(rx_word)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_o[g]   = (cfg.run_en && cfg.slave_sel == 4'(g)) ? cfg.sel_pol : ~cfg.sel_pol;
    assign cs_act[g] = cs_o[g] == cfg.sel_pol;
  end

  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_act)) else $error("several selects active"); // R3

endmodule

// File: tb/spi_pio_master_tb_top.sv
module spi_pio_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic sclk_o, mosi_o, miso = 1'b0;
  logic [3:0] cs_o;

  int n_chk = 0, n_err = 0;
  logic [31:0] last_rx = '0;

  // slave model state
  logic slv_arm = 1'b0, slv_cpha = 1'b0, mosi_prev = 1'b0;
  int slv_ec = 0, slv_len = 8, slv_idx = 0;
  logic [31:0] slv_word = '0, slv_cap = '0;

  spi_pio_master dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr_en(wr_en), .host_rd_en(rd_en),
    .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso), .cs_o(cs_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) mosi_prev <= mosi_o;

  always @(sclk_o) begin
    if (slv_arm) begin
      slv_ec = slv_ec + 1;
      if (slv_cpha ? (slv_ec % 2 == 0) : (slv_ec % 2 == 1))
        slv_cap = {slv_cap[30:0], mosi_prev};
      slv_idx = slv_cpha ? (slv_ec - 1) / 2 : slv_ec / 2;
      miso = (slv_idx < slv_len) ? slv_word[slv_len-1-slv_idx] : 1'b0;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_cfg(logic cpha, logic cpol, logic epol, logic [4:0] lm1,
                                         logic [1:0] mode, logic [3:0] sel, logic en);
    logic [63:0] w = '0;
    w[0] = cpha; w[1] = cpol; w[2] = epol; w[8:4] = lm1;
    w[13:12] = mode; w[17:14] = sel; w[26] = en;
    return w;
  endfunction

  function automatic logic [3:0] exp_cs(logic [3:0] sel, logic epol, logic en);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = (en && sel == 4'(i)) ? epol : ~epol;
    return v;
  endfunction

  function automatic int eff_len(logic [4:0] lm1);
    return (lm1 < 3) ? 4 : int'(lm1) + 1;
  endfunction

  function automatic logic [31:0] lmask(int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
  endfunction

  task automatic wr(logic [5:0] a, logic [63:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [63:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic peek(logic [5:0] a, output logic [63:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic arm_slave(logic [31:0] w, int len, logic cpha);
    slv_word = w; slv_len = len; slv_cpha = cpha; slv_ec = 0; slv_cap = '0;
    miso = w[len-1]; slv_arm = 1'b1;
  endtask

  task automatic wait_eot(output int cnt);
    logic [63:0] st;
    cnt = 0;
    peek(6'h08, st);
    while (!st[2] && cnt < 100000) begin
      cnt++;
      peek(6'h08, st);
    end
  endtask

  task automatic run_word(logic [1:0] mode, logic [4:0] lm1, logic cpha, logic cpol,
                          logic [13:0] dv, logic [3:0] sel, logic epol,
                          logic [31:0] tx, logic [31:0] sw);
    int len, cnt;
    logic [31:0] m;
    logic [63:0] st, d;
    len = eff_len(lm1); m = lmask(len);
    wr(6'h28, 64'(dv));
    wr(6'h00, mk_cfg(cpha, cpol, epol, lm1, mode, sel, 1'b1));
    @(negedge clk);
    chk("R3 select asserted", 64'(cs_o), 64'(exp_cs(sel, epol, 1'b1)));
    chk("R7 idle level", 64'(sclk_o), 64'(cpol));
    arm_slave(sw, len, cpha);
    wr(6'h18, 64'(tx));
    wait_eot(cnt);
    slv_arm = 1'b0;
    chk("R8 word duration", 64'(cnt), 64'(2 * len * (int'(dv) + 1)));
    chk("R5 edge count", 64'(slv_ec), 64'(2 * len));
    chk("R6 MOSI word", 64'(slv_cap & m), 64'((mode == 2'd1) ? 32'd0 : (tx & m)));
    chk("R7 idle after word", 64'(sclk_o), 64'(cpol));
    chk("R3 select held", 64'(cs_o), 64'(exp_cs(sel, epol, 1'b1)));
    peek(6'h08, st);
    chk("R11 rx ready on finish", 64'(st[0]), 64'(mode != 2'd2));
    if (mode != 2'd2) last_rx = sw & m;
    rd(6'h20, d);
    chk("R6 R11 received word", d, 64'(last_rx));
    peek(6'h08, st);
    chk("R11 rx ready cleared", 64'(st[0]), 64'd0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 19000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [63:0] d, cfg_a;
    int cnt;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 selects", 64'(cs_o), 64'hF);
    chk("R1 sclk", 64'(sclk_o), 64'd0);
    chk("R1 mosi", 64'(mosi_o), 64'd0);
    peek(6'h00, d); chk("R1 config", d, 64'd0);
    peek(6'h08, d); chk("R1 status", d, 64'h54);
    peek(6'h20, d); chk("R1 rx data", d, 64'd0);

    // R2 map and readback
    wr(6'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    peek(6'h00, d); chk("R2 config readback", d, 64'h07FF_F1FF);
    chk("R3 out-of-range select", 64'(cs_o), 64'h0);
    wr(6'h10, 64'h1);
    peek(6'h10, d); chk("R2 fifo slot", d, 64'd0);
    peek(6'h30, d); chk("R2 unmapped", d, 64'd0);
    wr(6'h28, 64'hFFFF);
    peek(6'h28, d); chk("R2 divider", d, 64'h3FFF);

    // R4 status with run bit and idle
    wr(6'h00, mk_cfg(0, 0, 0, 5'd7, 2'd0, 4'd1, 1'b1));
    peek(6'h08, d); chk("R4 status running idle", d, 64'h56);

    // R9 write with run bit clear
    wr(6'h00, mk_cfg(0, 0, 0, 5'd7, 2'd0, 4'd1, 1'b0));
    @(negedge clk); chk("R3 released", 64'(cs_o), 64'hF);
    arm_slave(32'hA5, 8, 1'b0);
    wr(6'h18, 64'h3C);
    repeat (20) @(negedge clk);
    slv_arm = 1'b0;
    chk("R9 no edges when stopped", 64'(slv_ec), 64'd0);
    peek(6'h08, d); chk("R9 status unchanged", d, 64'h54);

    // directed words
    run_word(2'd0, 5'd7,  0, 0, 14'd1, 4'd0, 0, 32'h0000_00A7, 32'h0000_005C);
    run_word(2'd0, 5'd31, 1, 1, 14'd0, 4'd1, 0, 32'hDEAD_BEEF, 32'h1234_5678);
    run_word(2'd0, 5'd1,  0, 1, 14'd2, 4'd2, 1, 32'hFFFF_FFF9, 32'hFFFF_FFF6); // R5 clamp
    run_word(2'd1, 5'd11, 1, 0, 14'd1, 4'd3, 0, 32'hFFFF_FFFF, 32'h0000_0ABC);
    run_word(2'd2, 5'd15, 0, 1, 14'd0, 4'd0, 1, 32'h0000_C3A5, 32'h0000_FFFF);
    run_word(2'd3, 5'd4,  1, 1, 14'd3, 4'd2, 0, 32'h0000_0013, 32'h0000_0015);

    // R9 R10 writes during a word
    wr(6'h28, 64'd2);
    cfg_a = mk_cfg(0, 0, 0, 5'd15, 2'd0, 4'd1, 1'b1);
    wr(6'h00, cfg_a);
    arm_slave(32'h0000_6E21, 16, 1'b0);
    wr(6'h18, 64'h0000_9ABC);
    repeat (5) @(negedge clk);
    wr(6'h18, 64'h0000_FFFF);
    wr(6'h00, mk_cfg(1, 1, 1, 5'd3, 2'd2, 4'd3, 1'b1));
    wr(6'h28, 64'd0);
    wait_eot(cnt);
    slv_arm = 1'b0;
    chk("R9 word in flight kept", 64'(slv_cap & 32'hFFFF), 64'h9ABC);
    chk("R9 edge count kept", 64'(slv_ec), 64'd32);
    peek(6'h00, d); chk("R10 config held", d, cfg_a);
    peek(6'h28, d); chk("R10 divider held", d, 64'd2);
    chk("R10 select held", 64'(cs_o), 64'(exp_cs(4'd1, 1'b0, 1'b1)));
    rd(6'h20, d); chk("R11 word after ignores", d, 64'h6E21);
    last_rx = 32'h6E21;

    // random words
    for (int i = 0; i < 40; i++) begin
      run_word(2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 14'($urandom_range(0, 3)), 4'($urandom_range(0, 3)),
               1'($urandom_range(0, 1)), $urandom, $urandom);
    end

    // R8 slowest rate: first edge after 2^14 cycles
    wr(6'h28, 64'd16383);
    wr(6'h00, mk_cfg(0, 0, 0, 5'd3, 2'd0, 4'd0, 1'b1));
    wr(6'h18, 64'h5);
    cnt = 0;
    @(negedge clk);
    while (sclk_o == 1'b0 && cnt < 20000) begin
      cnt++;
      @(negedge clk);
    end
    chk("R8 slowest half period", 64'(cnt), 64'd16384);

    // R1 reset during a word
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 selects after reset", 64'(cs_o), 64'hF);
    chk("R1 sclk after reset", 64'(sclk_o), 64'd0);
    peek(6'h08, d); chk("R1 status after reset", d, 64'h54);
    peek(6'h20, d); chk("R1 rx after reset", d, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule